// File: doc/BRIEF.md
# ModR/M Effective Address Generator

This unit turns an addressing-form byte, and the instruction bytes that follow it, into a 32-bit effective address for a 32-bit integer core. The decoder offers the form byte and the next four stream bytes on a valid/ready input. The unit then indexes the register file with the low three bits of the form byte and combines the base value it reads back with any displacement. One cycle later it presents the address, the number of displacement bytes it used, and flags that steer the rest of the pipeline.

The form byte has three fields. Bits 7:6 are the mode, bits 5:3 are a register or sub-operation field, and bits 2:0 select the base register. Mode 11 names a register operand instead of memory. Modes 00, 01 and 10 give register-indirect, register plus 8-bit displacement and register plus 32-bit displacement. There is one exception: mode 00 with a base field of 101 means the four following bytes are an absolute address. A base field of 100 in a memory mode would call for an index byte, which this unit does not decode, so it reports that case as unsupported. A load-address request computes the same address but marks it as needing no memory access.

Top module: `modrm_ea_gen`

## Requirements
- R1: After an input accept, `in_ready` is low for exactly one cycle and `rf_idx` carries the accepted base field. `out_valid` is high for exactly one cycle, starting two clock edges after the accepting edge. `in_ready` is high again in that same cycle.
- R2: In mode 00 with a base field other than 100 and 101, the address is the register value unchanged and the byte count is 0.
- R3: In mode 00 with base field 101, the address is the four tail bytes read little-endian (`in_tail[7:0]` is the lowest byte), the byte count is 4, and the register value is ignored.
- R4: In mode 01, `in_tail[7:0]` is sign-extended and added to the register value, and the byte count is 1. The upper tail bytes are ignored.
- R5: In mode 10, the 32-bit tail is added modulo 2^32 to the register value, and the byte count is 4.
- R6: In modes 01 and 10, a register value of zero gives address zero with no displacement added. The byte count is still 1 or 4.
- R7: Mode 11 sets `out_direct` and puts the base field on `out_reg`. The address is 0, the byte count is 0 and `out_mem` is low.
- R8: A base field of 100 in modes 00, 01 or 10 sets `out_unsup`. The address is 0, the byte count is 0 and `out_mem` is low.
- R9: With `in_lea` high, the address is computed as normal and `out_mem` is low. Otherwise `out_mem` is high for every supported memory form. `out_sub` always echoes bits 5:3 of the form byte.
- R10: While reset is held, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Form byte and tail bytes are offered |
| in_ready | output | 1 | Unit can accept a new form byte |
| in_modrm | input | 8 | Addressing-form byte |
| in_tail | input | 32 | The next four stream bytes, first byte in bits 7:0 |
| in_lea | input | 1 | Address-only request, no memory access wanted |
| rf_idx | output | 3 | Register-file read index (base field) |
| rf_data | input | 32 | Register-file read data, same cycle |
| out_valid | output | 1 | One-cycle result strobe |
| out_addr | output | 32 | Effective address |
| out_used | output | 3 | Displacement bytes consumed: 0, 1 or 4 |
| out_direct | output | 1 | Operand is a register, not memory |
| out_reg | output | 3 | Register index when `out_direct` is set |
| out_sub | output | 3 | Echo of form-byte bits 5:3 |
| out_unsup | output | 1 | Form needs index-byte decoding |
| out_mem | output | 1 | A memory access should follow |

## Verification
Each request is accepted on one edge, reads the register file during the following cycle, and has its result registered on the edge after that. So `in_ready` low and `rf_idx` are due one cycle after the accept, and every result field is due two cycles after it. The bench drives a request on a falling edge and samples at each of the next three falling edges. At those points it checks the busy cycle, the result cycle and the return to idle against a behavioural model, so every field is compared in the one cycle where it must be valid and the strobe is shown low on either side.

// File: rtl/modrm_ea_gen.sv
module modrm_ea_gen (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [7:0]  in_modrm,
  input  logic [31:0] in_tail,
  input  logic        in_lea,
  output logic [2:0]  rf_idx,
  input  logic [31:0] rf_data,
  output logic        out_valid,
  output logic [31:0] out_addr,
  output logic [2:0]  out_used,
  output logic        out_direct,
  output logic [2:0]  out_reg,
  output logic [2:0]  out_sub,
  output logic        out_unsup,
  output logic        out_mem
);
  logic        busy;
  logic [7:0]  form_q;
  logic [31:0] tail_q;
  logic        lea_q;

  wire take = in_valid && in_ready;
  assign in_ready = !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      form_q <= 8'h0;
      tail_q <= 32'h0;
      lea_q  <= 1'b0;
    end else if (take) begin
      busy   <= 1'b1;
      form_q <= in_modrm;
      tail_q <= in_tail;
      lea_q  <= in_lea;
    end else begin
      busy   <= 1'b0;
    end
  end

  wire [1:0] mode = form_q[7:6];
  wire [2:0] rm   = form_q[2:0];
  assign rf_idx = rm;

  wire is_dir = (mode == 2'b11);
  wire is_sib = !is_dir && (rm == 3'd4);
  wire is_abs = (mode == 2'b00) && (rm == 3'd5);

  logic [31:0] disp;
  logic [31:0] addr_c;
  logic [2:0]  used_c;

  always_comb begin
    disp = (mode == 2'b01) ? {{24{tail_q[7]}}, tail_q[7:0]} : tail_q;
    if (is_dir || is_sib) begin
      addr_c = 32'h0;
      used_c = 3'd0;
    end else if (is_abs) begin
      addr_c = tail_q;
      used_c = 3'd4;
    end else if (mode == 2'b00) begin
      addr_c = rf_data;
      used_c = 3'd0;
    end else begin
      addr_c = (rf_data == 32'h0) ? 32'h0 : rf_data + disp;
      used_c = (mode == 2'b01) ? 3'd1 : 3'd4;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_addr   <= 32'h0;
      out_used   <= 3'd0;
      out_direct <= 1'b0;
      out_reg    <= 3'd0;
      out_sub    <= 3'd0;
      out_unsup  <= 1'b0;
      out_mem    <= 1'b0;
    end else begin
      out_valid <= busy;
      if (busy) begin
        out_addr   <= addr_c;
        out_used   <= used_c;
        out_direct <= is_dir;
        out_reg    <= is_dir ? rm : 3'd0;
        out_sub    <= form_q[5:3];
        out_unsup  <= is_sib;
        out_mem    <= !is_dir && !is_sib && !lea_q;
      end
    end
  end

  a_r1_busy_after_take: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !in_ready);
  a_r1_index_follows_take: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> rf_idx == $past(in_modrm[2:0]));
  a_r1_result_due: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> ##1 out_valid);
  a_r1_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);
  a_r7_direct_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_direct) |-> (!out_mem && out_used == 3'd0 && out_addr == 32'h0));
  a_r8_unsup_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_unsup) |-> (!out_mem && out_used == 3'd0 && out_addr == 32'h0));
  a_r7_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(out_direct && out_unsup));
  a_r6_zero_stays_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && mode[1] != mode[0] && rf_data == 32'h0 && rm != 3'd4) |=> out_addr == 32'h0);
endmodule

// File: tb/modrm_ea_gen_tb.sv
module modrm_ea_gen_tb_top;
  localparam int CLK_NS = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [7:0] in_modrm = 8'h0;
  logic [31:0] in_tail = 32'h0;
  logic in_lea = 1'b0;
  logic in_ready, out_valid, out_direct, out_unsup, out_mem;
  logic [2:0] rf_idx, out_used, out_reg, out_sub;
  logic [31:0] rf_data, out_addr;
  logic [31:0] regs [8];

  int checks = 0;
  int errors = 0;

  always #(CLK_NS/2) clk = ~clk;
  assign rf_data = regs[rf_idx];

  modrm_ea_gen dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_modrm(in_modrm), .in_tail(in_tail), .in_lea(in_lea),
    .rf_idx(rf_idx), .rf_data(rf_data), .out_valid(out_valid),
    .out_addr(out_addr), .out_used(out_used), .out_direct(out_direct),
    .out_reg(out_reg), .out_sub(out_sub), .out_unsup(out_unsup), .out_mem(out_mem)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic send(input string tag, input logic [7:0] f, input logic [31:0] t, input logic lea);
    int mode, rm;
    logic [31:0] base, e_addr, ext;
    int e_used;
    bit e_dir, e_uns, e_mem;
    mode = f / 64;
    rm = f % 8;
    base = regs[rm];
    e_addr = 0; e_used = 0; e_dir = 0; e_uns = 0;
    if (mode == 3) e_dir = 1;
    else if (rm == 4) e_uns = 1;
    else if (mode == 0 && rm == 5) begin e_addr = t; e_used = 4; end
    else if (mode == 0) e_addr = base;
    else begin
      if (mode == 1) begin
        ext = (t % 256 >= 128) ? (t % 256) + 32'hFFFFFF00 : t % 256;
        e_used = 1;
      end else begin
        ext = t;
        e_used = 4;
      end
      e_addr = (base == 0) ? 0 : base + ext;
    end
    e_mem = !e_dir && !e_uns && !lea;
    chk({tag, " R1 ready before"}, in_ready, 1);
    in_modrm = f; in_tail = t; in_lea = lea; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; in_tail = 32'hDEAD_BEEF; in_modrm = 8'h00;
    chk({tag, " R1 busy"}, in_ready, 0);
    chk({tag, " R1 rf_idx"}, rf_idx, rm);
    chk({tag, " R1 not yet valid"}, out_valid, 0);
    @(negedge clk);
    chk({tag, " R1 valid"}, out_valid, 1);
    chk({tag, " R1 ready in result cycle"}, in_ready, 1);
    chk({tag, " addr"}, out_addr, e_addr);
    chk({tag, " used"}, out_used, e_used);
    chk({tag, " R7 direct"}, out_direct, e_dir);
    chk({tag, " R7 reg"}, out_reg, e_dir ? rm : 0);
    chk({tag, " R8 unsup"}, out_unsup, e_uns);
    chk({tag, " R9 mem"}, out_mem, e_mem);
    chk({tag, " R9 sub"}, out_sub, (f / 8) % 8);
    @(negedge clk);
    chk({tag, " R1 pulse ends"}, out_valid, 0);
  endtask

  initial begin
    #(CLK_NS * 100000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) regs[i] = 32'h0;
    repeat (3) @(negedge clk);
    chk("R10 valid in reset", out_valid, 0);
    chk("R10 ready in reset", in_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    regs[0] = 32'h0000_2000; regs[5] = 32'h0000_3000; regs[3] = 32'h0;
    regs[1] = 32'h0000_2001; regs[2] = 32'h0000_1FFE; regs[6] = 32'h8000_0000;
    send("R2 indirect", 8'h18, 32'h1111_1111, 0);
    send("R3 absolute", 8'h1D, 32'h0000_2000, 0);
    send("R3 absolute bytes", 8'h05, 32'h4433_2211, 0);
    send("R4 neg byte", 8'h41, 32'hAABB_CCFF, 0);
    send("R4 pos byte", 8'h42, 32'h1234_5602, 0);
    send("R4 rm5 base", 8'h45, 32'h0000_0010, 0);
    send("R5 pos disp", 8'h82, 32'h0000_0002, 0);
    send("R5 neg disp", 8'h81, 32'hFFFF_FFFF, 0);
    send("R5 wrap", 8'h86, 32'h8000_0000, 0);
    send("R6 zero base d8", 8'h43, 32'h0000_0055, 0);
    send("R6 zero base d32", 8'h83, 32'h0000_1000, 0);
    send("R7 direct", 8'hDB, 32'h0000_0000, 0);
    send("R8 sib m0", 8'h04, 32'h0000_2000, 0);
    send("R8 sib m1", 8'h54, 32'h0000_2000, 0);
    send("R8 sib m2", 8'hA4, 32'h0000_2000, 0);
    send("R9 lea", 8'h59, 32'h0000_00FF, 1);
    send("R9 lea abs", 8'h2D, 32'h0BAD_F00D, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule